// File: doc/BRIEF.md
# Indirect Switch Register Access Sequencer

This block gives a host one-request-at-a-time access to the internal registers of a switch device. The switch does not expose these registers directly. Instead it provides a two-register indirect window behind a simple register-access port: a command register and a data register. The lower port is modelled as a request/acknowledge handshake with a 5-bit register address and 16-bit data. Generating serial management frames is outside this block.

For each host request, the sequencer runs the full indirect transaction. It reads the command register until the device reports that it is idle, and it writes the command and data registers in the order the access type needs. For a read, it then fetches the result from the data register. It ends with a one-cycle completion pulse and an error flag. An error reported by the lower port, or a device that stays busy for too long, ends the request early with the error flag set.

Top module: `swi_access_seq`

## Requirements
- R1: After reset `ready_o` is 1, `done_o`, `err_o` and `mreq_o` are 0, and `rdata_o` is 0.
- R2: The command word has bit 15 (start) set, bit 12 set and bits 14:13 clear. Bits 11:10 hold the opcode, 2'b10 for a read and 2'b01 for a write. Bits 9:5 hold the port/device field and bits 4:0 hold the register number.
- R3: The port/device and register inputs are reduced to their low 5 bits before they enter the command word. Higher input bits have no effect on any word sent to the device.
- R4: Each phase of waiting for not-busy reads address `CMD_ADDR` (default 0) and repeats until a read returns bit 15 clear. Every bit other than bit 15 of those reads is ignored.
- R5: If `POLL_LIMIT` consecutive reads in one waiting phase all return bit 15 set, the request ends with `done_o` and `err_o` both 1, and no further access is made.
- R6: A write request performs these steps in order: wait for not-busy, write the data to `DATA_ADDR` (default 1), write the command word to `CMD_ADDR`, and wait for not-busy. It then completes without error.
- R7: A read request performs these steps in order: wait for not-busy, write the command word, wait for not-busy, and read `DATA_ADDR`. The value read appears on `rdata_o` together with `done_o`.
- R8: An access acknowledged with `merr_i` high ends the request at once with `done_o` and `err_o` both 1, and no further access is made.
- R9: `ready_o` is 1 only while the block is idle. A request offered while `ready_o` is 0 is ignored, and while `ready_o` is 1 the lower port is quiet.
- R10: `done_o` is a single-cycle pulse, one cycle after the last acknowledge. `err_o` is only ever 1 together with `done_o`.
- R11: A lower-port request holds its address, direction and write data steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request offered |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_port_i | input | FIELD_IN_W | Port/device field (low 5 bits used) |
| req_reg_i | input | FIELD_IN_W | Register number (low 5 bits used) |
| req_wdata_i | input | 16 | Write value |
| ready_o | output | 1 | Idle, request accepted |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 1 | Request finished with error |
| rdata_o | output | 16 | Last value read |
| mreq_o | output | 1 | Lower-port access request |
| mwe_o | output | 1 | Lower-port access is a write |
| maddr_o | output | ADDR_W | Lower-port register address |
| mwdata_o | output | 16 | Lower-port write data |
| mack_i | input | 1 | Lower-port acknowledge |
| merr_i | input | 1 | Lower-port error, valid with acknowledge |
| mrdata_i | input | 16 | Lower-port read data, valid with acknowledge |

## Verification
The bench builds the block with `POLL_LIMIT` = 4 and `FIELD_IN_W` = 7. The small limit lets the bench sweep every busy count from zero to past the limit in both waiting phases, for both access types. The 7-bit fields let a sweep over all 128 port values, with a register number containing high bits, show the masking in every command word. With the short transactions, the bench can also inject a lower-port error at every access position of a read and of a write.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int unsigned FLD_W    = 5;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned BUSY_BIT = 15;
  localparam int unsigned MARK_BIT = 12;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } swi_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_PRE,
    ST_DATA_WR,
    ST_CMD_WR,
    ST_POLL_POST,
    ST_DATA_RD
  } swi_state_e;

  typedef struct packed {
    logic              is_wr;
    logic [WORD_W-1:0] cmd;
    logic [WORD_W-1:0] wdata;
  } swi_job_t;
endpackage

// File: rtl/swi_cmd_pack.sv
module swi_cmd_pack
  import swi_pkg::*;
#(
  parameter int unsigned IN_W = 5
) (
  input  logic              is_wr_i,
  input  logic [IN_W-1:0]   port_i,
  input  logic [IN_W-1:0]   reg_i,
  output logic [WORD_W-1:0] word_o
);
  logic [FLD_W-1:0] port_m;
  logic [FLD_W-1:0] reg_m;
  swi_op_e          op;

  // keep only the low field bits
  assign port_m = FLD_W'(port_i);
  assign reg_m  = FLD_W'(reg_i);
  assign op     = is_wr_i ? OP_WR : OP_RD;

  always_comb begin
    word_o           = '0;
    word_o[BUSY_BIT] = 1'b1;
    word_o[MARK_BIT] = 1'b1;
    word_o[11:10]    = op;
    word_o[9:5]      = port_m;
    word_o[4:0]      = reg_m;
  end
endmodule

// File: rtl/swi_poll_ctr.sv
module swi_poll_ctr #(
  parameter int unsigned POLL_LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(POLL_LIMIT - 1));

  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(POLL_LIMIT)); // R5
endmodule

// File: rtl/swi_seq_fsm.sv
module swi_seq_fsm
  import swi_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned CMD_ADDR  = 0,
  parameter int unsigned DATA_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [WORD_W-1:0] req_cmd_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              mreq_o,
  output logic              mwe_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [WORD_W-1:0] mwdata_o,
  input  logic              mack_i,
  input  logic              merr_i,
  input  logic [WORD_W-1:0] mrdata_i,
  input  logic              poll_last_i,
  output logic              poll_clr_o,
  output logic              poll_step_o
);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  swi_state_e       st_q;
  swi_job_t         job_q;
  logic             done_q, err_q;
  logic [WORD_W-1:0] rdata_q;
  logic             polling, busy_seen, timed_out;

  assign polling     = (st_q == ST_POLL_PRE) || (st_q == ST_POLL_POST);
  assign busy_seen   = mrdata_i[BUSY_BIT];
  assign poll_clr_o  = (st_q == ST_IDLE) || (polling && mack_i && !busy_seen);
  assign poll_step_o = polling && mack_i && !merr_i && busy_seen && !poll_last_i;
  assign timed_out   = polling && mack_i && !merr_i && busy_seen && poll_last_i;

  always_comb begin
    mreq_o   = 1'b0;
    mwe_o    = 1'b0;
    maddr_o  = CMD_A;
    mwdata_o = job_q.cmd;
    unique case (st_q)
      ST_POLL_PRE, ST_POLL_POST: mreq_o = 1'b1;
      ST_DATA_WR: begin
        mreq_o   = 1'b1;
        mwe_o    = 1'b1;
        maddr_o  = DATA_A;
        mwdata_o = job_q.wdata;
      end
      ST_CMD_WR: begin
        mreq_o = 1'b1;
        mwe_o  = 1'b1;
      end
      ST_DATA_RD: begin
        mreq_o  = 1'b1;
        maddr_o = DATA_A;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      job_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (req_valid_i) begin
          job_q <= '{is_wr: req_write_i, cmd: req_cmd_i, wdata: req_wdata_i};
          st_q  <= ST_POLL_PRE;
        end
      end else if (mack_i) begin
        if (merr_i || timed_out) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          unique case (st_q)
            ST_POLL_PRE:
              if (!busy_seen) st_q <= job_q.is_wr ? ST_DATA_WR : ST_CMD_WR;
            ST_DATA_WR: st_q <= ST_CMD_WR;
            ST_CMD_WR:  st_q <= ST_POLL_POST;
            ST_POLL_POST:
              if (!busy_seen) begin
                if (job_q.is_wr) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                end else begin
                  st_q <= ST_DATA_RD;
                end
              end
            ST_DATA_RD: begin
              rdata_q <= mrdata_i;
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
            end
            default: st_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign ready_o = (st_q == ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_o && !mack_i |=> mreq_o && $stable(maddr_o) && $stable(mwe_o) && $stable(mwdata_o)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mreq_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
  AST_CMD_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_o && mwe_o && (maddr_o == CMD_A) |->
      mwdata_o[BUSY_BIT] && mwdata_o[MARK_BIT] && (mwdata_o[14:13] == 2'b00) &&
      ((mwdata_o[11:10] == OP_WR) || (mwdata_o[11:10] == OP_RD))); // R2
endmodule

// File: rtl/swi_access_seq.sv
module swi_access_seq
  import swi_pkg::*;
#(
  parameter int unsigned FIELD_IN_W = 5,
  parameter int unsigned POLL_LIMIT = 100,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned CMD_ADDR   = 0,
  parameter int unsigned DATA_ADDR  = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [FIELD_IN_W-1:0] req_port_i,
  input  logic [FIELD_IN_W-1:0] req_reg_i,
  input  logic [15:0]           req_wdata_i,
  output logic                  ready_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic [15:0]           rdata_o,
  output logic                  mreq_o,
  output logic                  mwe_o,
  output logic [ADDR_W-1:0]     maddr_o,
  output logic [15:0]           mwdata_o,
  input  logic                  mack_i,
  input  logic                  merr_i,
  input  logic [15:0]           mrdata_i
);
  logic [WORD_W-1:0] cmd_word;
  logic              poll_last, poll_clr, poll_step;

  swi_cmd_pack #(.IN_W(FIELD_IN_W)) u_pack (
    .is_wr_i (req_write_i),
    .port_i  (req_port_i),
    .reg_i   (req_reg_i),
    .word_o  (cmd_word)
  );

  swi_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .step_i (poll_step),
    .last_o (poll_last)
  );

  swi_seq_fsm #(
    .ADDR_W    (ADDR_W),
    .CMD_ADDR  (CMD_ADDR),
    .DATA_ADDR (DATA_ADDR)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_cmd_i   (cmd_word),
    .req_wdata_i (req_wdata_i),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o),
    .mreq_o      (mreq_o),
    .mwe_o       (mwe_o),
    .maddr_o     (maddr_o),
    .mwdata_o    (mwdata_o),
    .mack_i      (mack_i),
    .merr_i      (merr_i),
    .mrdata_i    (mrdata_i),
    .poll_last_i (poll_last),
    .poll_clr_o  (poll_clr),
    .poll_step_o (poll_step)
  );
endmodule

// File: tb/swi_access_seq_tb.sv
module swi_access_seq_tb;
  localparam int LIM = 4;
  localparam int FW  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [FW-1:0] req_port = '0, req_reg = '0;
  logic [15:0]   req_wdata = '0;
  logic          ready, done, err;
  logic [15:0]   rdata;
  logic          mreq, mwe;
  logic [4:0]    maddr;
  logic [15:0]   mwdata;
  logic          mack = 1'b0, merr = 1'b0;
  logic [15:0]   mrdata = '0;

  swi_access_seq #(.FIELD_IN_W(FW), .POLL_LIMIT(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_port_i(req_port), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mreq_o(mreq), .mwe_o(mwe), .maddr_o(maddr), .mwdata_o(mwdata),
    .mack_i(mack), .merr_i(merr), .mrdata_i(mrdata)
  );

  int total = 0, bad = 0;

  // device model with access log
  int          busy_left = 0, post_busy = 0, err_at = -1, n_log = 0;
  logic [15:0] dev_data = '0;
  logic        l_we [64];
  logic [4:0]  l_addr [64];
  logic [15:0] l_wd [64];

  always @(posedge clk) begin
    if (mreq && !mack) begin
      mack <= 1'b1;
      merr <= (n_log == err_at);
      if (n_log < 64) begin
        l_we[n_log] = mwe; l_addr[n_log] = maddr; l_wd[n_log] = mwdata;
      end
      n_log = n_log + 1;
      if (mwe && maddr == 5'd0) begin
        busy_left = post_busy;
        if (mwdata[11:10] == 2'b10) dev_data = {mwdata[9:0], 6'b0} ^ 16'h3C5A;
      end else if (mwe && maddr == 5'd1) begin
        dev_data = mwdata;
      end else if (!mwe && maddr == 5'd0) begin
        mrdata <= {busy_left != 0, 15'h2AAA};
        if (busy_left > 0) busy_left = busy_left - 1;
      end else begin
        mrdata <= dev_data;
      end
    end else begin
      mack <= 1'b0;
      merr <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  logic        e_we [64];
  logic [4:0]  e_addr [64];
  logic [15:0] e_wd [64];
  int          n_exp;

  task automatic add_exp(input logic we, input logic [4:0] a, input logic [15:0] d);
    e_we[n_exp] = we; e_addr[n_exp] = a; e_wd[n_exp] = d; n_exp++;
  endtask

  task automatic txn(input bit wr, input int port, input int regn, input logic [15:0] wd,
                     input int pre, input int post, input int eat);
    logic [15:0] cmd, exp_rd;
    bit stop, exp_err, inj;
    string tg;
    int wait_cyc;
    cmd = 16'h9000 | (wr ? 16'h0400 : 16'h0800) | 16'((port & 31) << 5) | 16'(regn & 31);
    exp_rd = {5'(port & 31), 5'(regn & 31), 6'b0} ^ 16'h3C5A;
    tg = wr ? "R6" : "R7";
    // expected access list from the requirements
    n_exp = 0; stop = 0; exp_err = 0; inj = 0;
    for (int i = 0; i < (pre < LIM ? pre + 1 : LIM); i++) add_exp(1'b0, 5'd0, 16'h0);
    if (pre >= LIM) begin stop = 1; exp_err = 1; end
    if (!stop) begin
      if (wr) add_exp(1'b1, 5'd1, wd);
      add_exp(1'b1, 5'd0, cmd);
      for (int i = 0; i < (post < LIM ? post + 1 : LIM); i++) add_exp(1'b0, 5'd0, 16'h0);
      if (post >= LIM) begin stop = 1; exp_err = 1; end
      if (!stop && !wr) add_exp(1'b0, 5'd1, 16'h0);
    end
    if (eat >= 0 && eat < n_exp) begin n_exp = eat + 1; exp_err = 1; inj = 1; end

    @(negedge clk);
    n_log = 0; busy_left = pre; post_busy = post; err_at = eat;
    while (!ready) @(negedge clk);
    req_write = wr; req_port = FW'(port); req_reg = FW'(regn); req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    // a second request while busy must be ignored
    req_port = ~req_port; req_reg = ~req_reg; req_write = ~wr;
    chk(ready == 1'b0, "R9", "ready while busy", ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    wait_cyc = 0;
    while (!done && wait_cyc < 300) begin @(negedge clk); wait_cyc++; end
    chk(done == 1'b1, "R10", "done seen", done, 1);
    chk(err == exp_err, inj ? "R8" : (exp_err ? "R5" : "R10"), "err flag", err, exp_err);
    chk(n_log == n_exp, exp_err ? (inj ? "R8" : "R5") : tg, "access count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(l_we[i] == e_we[i] && l_addr[i] == e_addr[i], e_we[i] ? tg : "R4",
          "access kind/addr", {l_we[i], l_addr[i]}, {e_we[i], e_addr[i]});
      if (e_we[i])
        chk(l_wd[i] == e_wd[i], (e_addr[i] == 5'd0) ? ((port > 31 || regn > 31) ? "R3" : "R2") : "R6",
            "write data", l_wd[i], e_wd[i]);
    end
    if (!wr && !exp_err) chk(rdata == exp_rd, "R7", "read data", rdata, exp_rd);
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R10", "done pulse width", {done, err}, 0);
    chk(mreq == 1'b0, "R8", "quiet after end", mreq, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && done == 1'b0 && err == 1'b0 && mreq == 1'b0 && rdata == 16'h0,
        "R1", "reset state", {ready, done, err, mreq}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && mreq == 1'b0, "R1", "idle after reset", {ready, mreq}, 2'b10);
    // busy-count sweep on both phases (R4, R5, R6, R7)
    for (int wr = 0; wr < 2; wr++)
      for (int pre = 0; pre <= LIM + 1; pre++)
        for (int post = 0; post <= LIM + 1; post++)
          txn(wr[0], (pre * 19 + post * 7 + wr * 3) % 128, (pre * 5 + post * 23 + wr * 11) % 128,
              16'(pre * 4096 + post * 256 + wr * 17 + 3), pre, post, -1);
    // field sweep with high bits set (R2, R3)
    for (int p = 0; p < 128; p++)
      txn(p[0], p, p ^ 7'h55, 16'(p * 515), 1, 1, -1);
    // lower-port error at every position (R8)
    for (int wr = 0; wr < 2; wr++)
      for (int e = 0; e < 9; e++)
        txn(wr[0], 37, 101, 16'hBEEF, 1, 2, e);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule